// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two bidirectional data ports, A and B, through a pair of storage registers. One register samples the A port on the rising edge of its own clock. The other samples the B port on the rising edge of a second, independent clock. Both registers keep sampling in every drive setting, including while their own port is driving.

Two enables set the direction. The A-to-B enable is active high and makes the B port drive. The B-to-A enable is active low and makes the A port drive. Each port may drive on its own, both may drive, or neither. A select for each direction picks what a driving port carries: either the live value on the opposite port, or the opposite port's stored register.

When both ports drive, a port never carries the live input of the other port, because that would form a combinational loop. Each pad is split into an input vector, an output vector and one output-enable bit. The pad value seen by the block is the block's own output while it drives, and the external input otherwise.

Top module: `regbus_xcvr`

## Requirements
- R1: With the A-to-B enable low and the B-to-A enable high, a_oe and b_oe are both 0.
- R2: On each rising edge of clk_a without reset, the A register loads the A pad value. The A pad value is a_out when a_oe is 1 and a_in otherwise.
- R3: On each rising edge of clk_b without reset, the B register loads the B pad value. The B pad value is b_out when b_oe is 1 and b_in otherwise.
- R4: When only B drives (en_ab=1, en_ba_n=1), b_out equals a_in while sel_ab=0, and equals the A register while sel_ab=1.
- R5: When only A drives (en_ab=0, en_ba_n=0), a_out equals b_in while sel_ba=0, and equals the B register while sel_ba=1.
- R6: When both ports drive and both selects are 1, a_out equals the B register and b_out equals the A register.
- R7: When both ports drive, a port whose select is 0 still carries the opposite port's register, not the live input.
- R8: A register reload reaches any port that shows it right after the clock edge, including while that register's own port is driving.
- R9: A clock edge with rst=1 clears that clock's register to zero.
- R10: A port whose output enable is 0 presents zero on its output vector.
- R11: A register holds its value across edges of the other clock and across changes of the enables and selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Capture clock of the A register |
| clk_b | input | 1 | Capture clock of the B register |
| rst | input | 1 | Synchronous active-high clear, sampled by each clock |
| en_ab | input | 1 | Active-high enable for B port drive |
| en_ba_n | input | 1 | Active-low enable for A port drive |
| sel_ab | input | 1 | B drive source: 0 live A, 1 A register |
| sel_ba | input | 1 | A drive source: 0 live B, 1 B register |
| a_in | input | WIDTH | External value on the A pads |
| a_out | output | WIDTH | Value driven onto the A pads |
| a_oe | output | 1 | A pad drive enable |
| b_in | input | WIDTH | External value on the B pads |
| b_out | output | WIDTH | Value driven onto the B pads |
| b_oe | output | 1 | B pad drive enable |

## Verification
The bench sweeps all sixteen settings of the two enables and two selects. Each setting is combined with all four patterns of which clocks pulse, so captures in both directions, one-sided captures and holds are each observed. Every setting is also tried with varied A and B data, which tells live pass-through apart from stored output, and tells the both-drive cross path apart from the single-direction path. Outputs are checked once before and once after each edge, so a reload that reaches a port at once is distinguished from one that arrives late.

// File: rtl/regbus_xcvr_pkg.sv
package regbus_xcvr_pkg;

    typedef enum logic [1:0] {
        SRC_OFF    = 2'd0,
        SRC_LIVE   = 2'd1,
        SRC_STORED = 2'd2
    } drive_src_e;

    // A driving port shows the peer register when its select asks for it,
    // or when the peer also drives (live path would close a loop).
    function automatic drive_src_e pick_src(input logic drive,
                                            input logic use_reg,
                                            input logic peer_drives);
        if (!drive)
            return SRC_OFF;
        else if (use_reg || peer_drives)
            return SRC_STORED;
        else
            return SRC_LIVE;
    endfunction

endpackage

// File: rtl/regbus_cap_reg.sv
module regbus_cap_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pad,
    output logic [WIDTH-1:0] q
);

    typedef struct packed {
        logic [WIDTH-1:0] data;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst)
            st_d.data = '0;
        else
            st_d.data = pad;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.data;

endmodule

// File: rtl/regbus_port_mux.sv
module regbus_port_mux
    import regbus_xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             drive,
    input  logic             use_reg,
    input  logic             peer_drives,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] stored,
    output logic [WIDTH-1:0] out,
    output logic             oe
);

    drive_src_e src;

    always_comb begin
        src = pick_src(drive, use_reg, peer_drives);
        unique case (src)
            SRC_LIVE:   out = live;
            SRC_STORED: out = stored;
            default:    out = '0;
        endcase
        oe = (src != SRC_OFF);
    end

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
    parameter int WIDTH = 8
) (
    input  logic             clk_a,
    input  logic             clk_b,
    input  logic             rst,
    input  logic             en_ab,
    input  logic             en_ba_n,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);

    localparam int SIDES = 2;
    localparam int SA    = 0;
    localparam int SB    = 1;

    logic             drive_a, drive_b;
    logic [WIDTH-1:0] a_q, b_q;
    logic [WIDTH-1:0] a_pad, b_pad;

    logic [SIDES-1:0]            side_clk;
    logic [SIDES-1:0][WIDTH-1:0] side_pad;
    logic [SIDES-1:0][WIDTH-1:0] side_q;

    assign drive_a = ~en_ba_n;
    assign drive_b = en_ab;

    // A port: shows B data
    regbus_port_mux #(.WIDTH(WIDTH)) u_mux_a (
        .drive       (drive_a),
        .use_reg     (sel_ba),
        .peer_drives (drive_b),
        .live        (b_in),
        .stored      (b_q),
        .out         (a_out),
        .oe          (a_oe)
    );

    // B port: shows A data
    regbus_port_mux #(.WIDTH(WIDTH)) u_mux_b (
        .drive       (drive_b),
        .use_reg     (sel_ab),
        .peer_drives (drive_a),
        .live        (a_in),
        .stored      (a_q),
        .out         (b_out),
        .oe          (b_oe)
    );

    // Pad value as seen at the pin
    assign a_pad = a_oe ? a_out : a_in;
    assign b_pad = b_oe ? b_out : b_in;

    assign side_clk[SA] = clk_a;
    assign side_clk[SB] = clk_b;
    assign side_pad[SA] = a_pad;
    assign side_pad[SB] = b_pad;

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        regbus_cap_reg #(.WIDTH(WIDTH)) u_cap (
            .clk (side_clk[s]),
            .rst (rst),
            .pad (side_pad[s]),
            .q   (side_q[s])
        );
    end

    assign a_q = side_q[SA];
    assign b_q = side_q[SB];

endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk_a,
    input logic             clk_b,
    input logic             rst,
    input logic             en_ab,
    input logic             en_ba_n,
    input logic             sel_ab,
    input logic             sel_ba,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] a_out,
    input logic             a_oe,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] b_out,
    input logic             b_oe,
    input logic [WIDTH-1:0] a_q,
    input logic [WIDTH-1:0] b_q
);

    logic [WIDTH-1:0] a_pin, b_pin;
    logic             live_a = 1'b0;
    logic             live_b = 1'b0;

    assign a_pin = a_oe ? a_out : a_in;
    assign b_pin = b_oe ? b_out : b_in;

    always_ff @(posedge clk_a) live_a <= ~rst;
    always_ff @(posedge clk_b) live_b <= ~rst;

    p_idle_hiz_r1: assert property (@(posedge clk_a) disable iff (rst)
        (!en_ab && en_ba_n) |-> (!a_oe && !b_oe));

    p_cap_a_r2: assert property (@(posedge clk_a) disable iff (rst)
        live_a |-> (a_q == $past(a_pin)));

    p_cap_b_r3: assert property (@(posedge clk_b) disable iff (rst)
        live_b |-> (b_q == $past(b_pin)));

    p_ab_live_r4: assert property (@(posedge clk_a) disable iff (rst)
        (en_ab && en_ba_n && !sel_ab) |-> (b_out == a_in));

    p_ba_live_r5: assert property (@(posedge clk_b) disable iff (rst)
        (!en_ab && !en_ba_n && !sel_ba) |-> (a_out == b_in));

    p_swap_r6: assert property (@(posedge clk_a) disable iff (rst)
        (a_oe && b_oe && sel_ab && sel_ba) |-> (a_out == b_q && b_out == a_q));

    p_both_nolive_r7: assert property (@(posedge clk_b) disable iff (rst)
        (a_oe && b_oe) |-> (a_out == b_q));

    p_clear_r9: assert property (@(posedge clk_a)
        rst |=> (a_q == '0));

    p_off_zero_r10: assert property (@(posedge clk_a) disable iff (rst)
        (!a_oe || !b_oe) |-> ((a_oe || a_out == '0) && (b_oe || b_out == '0)));

endmodule

bind regbus_xcvr regbus_xcvr_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_regbus_xcvr.sv
module tb_regbus_xcvr;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         run_a = 1'b0;
    logic         run_b = 1'b0;
    logic         clk_a, clk_b;
    logic         rst = 1'b0;
    logic         en_ab = 1'b0;
    logic         en_ba_n = 1'b1;
    logic         sel_ab = 1'b0;
    logic         sel_ba = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    logic [W-1:0] ra = '0;
    logic [W-1:0] rb = '0;

    always #5 clk = ~clk;
    assign clk_a = clk & run_a;
    assign clk_b = clk & run_b;

    regbus_xcvr #(.WIDTH(W)) dut (
        .clk_a   (clk_a),
        .clk_b   (clk_b),
        .rst     (rst),
        .en_ab   (en_ab),
        .en_ba_n (en_ba_n),
        .sel_ab  (sel_ab),
        .sel_ba  (sel_ba),
        .a_in    (a_in),
        .a_out   (a_out),
        .a_oe    (a_oe),
        .b_in    (b_in),
        .b_out   (b_out),
        .b_oe    (b_oe)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected outputs from the current model registers
    task automatic expect_out(output logic eoa, output logic eob,
                              output logic [W-1:0] ea, output logic [W-1:0] eb);
        eoa = ~en_ba_n;
        eob = en_ab;
        ea  = !eoa ? '0 : ((sel_ba || eob) ? rb : b_in);
        eb  = !eob ? '0 : ((sel_ab || eoa) ? ra : a_in);
    endtask

    function automatic string tag_of(input logic eoa, input logic eob, input bit for_a);
        if (!eoa && !eob) return "R1/R10";
        if (eoa && eob)   return (sel_ab && sel_ba) ? "R6" : "R7";
        if (eob)          return for_a ? "R10" : "R4";
        return for_a ? "R5" : "R10";
    endfunction

    task automatic compare_all(input string phase);
        logic eoa, eob;
        logic [W-1:0] ea, eb;
        expect_out(eoa, eob, ea, eb);
        check({tag_of(eoa, eob, 1'b1), " a_oe ", phase}, {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, eoa});
        check({tag_of(eoa, eob, 1'b0), " b_oe ", phase}, {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, eob});
        check({tag_of(eoa, eob, 1'b1), " a_out ", phase}, a_out, ea);
        check({tag_of(eoa, eob, 1'b0), " b_out ", phase}, b_out, eb);
    endtask

    task automatic step(input logic [3:0] mode, input logic [W-1:0] av, input logic [W-1:0] bv,
                        input logic ca, input logic cb, input logic rs);
        logic eoa, eob;
        logic [W-1:0] ea, eb, pa, pb;
        @(negedge clk);
        {en_ab, en_ba_n, sel_ab, sel_ba} = mode;
        a_in = av; b_in = bv; run_a = ca; run_b = cb; rst = rs;
        #2;
        if (!rs) compare_all("pre-edge");
        expect_out(eoa, eob, ea, eb);
        pa = eoa ? ea : av;   // R2: pad seen by A register
        pb = eob ? eb : bv;   // R3: pad seen by B register
        @(posedge clk);
        if (ca) ra = rs ? '0 : pa;  // R9 clear, R11 hold otherwise
        if (cb) rb = rs ? '0 : pb;
        #2;
        if (!rs) compare_all("post-edge R2 R3 R8 R11");
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            misses++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        // R9: clear both registers, then show both through the cross swap
        step(4'b1011, 8'h5A, 8'hC3, 1'b1, 1'b1, 1'b1);
        step(4'b1011, 8'h11, 8'h22, 1'b0, 1'b0, 1'b0);
        check("R9 a_out after reset", a_out, '0);
        check("R9 b_out after reset", b_out, '0);

        for (int m = 0; m < 16; m++) begin
            for (int c = 0; c < 4; c++) begin
                for (int d = 0; d < 4; d++) begin
                    int i;
                    i = m * 16 + c * 4 + d;
                    step(4'(m), W'((i * 37 + 5) & 8'hFF), W'(((i * 91) ^ 8'hA5) & 8'hFF),
                         c[0], c[1], 1'b0);
                end
            end
        end

        // R8: A reloads from a_in while B shows A register
        step(4'b1110, 8'h3C, 8'h00, 1'b1, 1'b0, 1'b0);
        check("R8 b_out shows fresh A register", b_out, 8'h3C);
        // R8: A drives stored B while B register reloads
        step(4'b0001, 8'h00, 8'h96, 1'b0, 1'b1, 1'b0);
        check("R8 a_out shows fresh B register", a_out, 8'h96);
        // R11: no clocks, data changes, registers unchanged
        step(4'b1011, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0);
        check("R11 a_out holds B register", a_out, 8'h96);
        check("R11 b_out holds A register", b_out, 8'h3C);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule